// File: doc/BRIEF.md
# DVMA Address Translator

This block turns 32-bit device addresses into physical addresses by walking a table of 64-bit entries kept in system memory. Translation covers a window that ends at the top of the 32-bit space. A 3-bit size code sets the window's width and its base address. Each 8 KB device page inside the window owns one table entry. The entry supplies the physical page number, a valid flag, a write permission and two attributes, cacheable and streamable, which are returned with the result.

Software programs three registers through a simple write port: control (enable and size code), table base, and a flush register that drops a cached translation. A device presents one address at a time on a valid/ready request port. The block checks the window, then looks in a single-entry translation cache. On a miss it issues one memory read for the entry, and it returns the physical address or a fault on a valid/ready response port. Only one request is in flight at any time.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0. Translation is disabled, the size code is 0, the table base is 0 and the cache is empty.
- R2: While the enable bit is 0, every request returns `rsp_fault`=1 and issues no memory read. Every faulting response carries `rsp_paddr`=0, `rsp_cacheable`=0 and `rsp_streamable`=0.
- R3: Control bits 18:16 hold the size code c. The window base is the low 32 bits of all-ones shifted left by 23+c, so c=0 gives 0xFF800000 and c=7 gives 0xC0000000. An address below the base faults and issues no read.
- R4: On a cache miss the block issues exactly one read, at the table base plus ((address − window base) >> 13) × 8.
- R5: A successful response returns `rsp_paddr` = {entry[40:13], address[12:0]}. `rsp_cacheable` is entry bit 4 and `rsp_streamable` is entry bit 60.
- R6: An entry with bit 63 clear faults, and it is not kept in the cache, so a repeat request reads memory again.
- R7: A write request faults when entry bit 1 is clear. A read request through the same entry succeeds.
- R8: A request to the same 8 KB page as the cached valid entry completes without a memory read and gives the same result a fetch would give.
- R9: A flush write whose data bits 31:13 match the cached page empties the cache. A flush of any other page leaves the cache intact.
- R10: A flush of page P in the same cycle that the entry for page P returns from memory wins: that entry is not retained.
- R11: Any write to the control or table-base register empties the cache.
- R12: From acceptance until the response handshake, `req_ready` is 0. `rsp_*` and `mem_rd_addr` hold steady while their ready input is low.
- R13: `reg_sel` encodes 0 = control (bit 0 enable), 1 = table base (bits 40:0), 2 = flush. Value 3 writes nothing. Control bits 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 base, 2 flush) |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device address to translate |
| req_write | input | 1 | Request is a write |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 41 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Fetched table entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Receiver accepts result |
| rsp_paddr | output | 41 | Physical address |
| rsp_cacheable | output | 1 | Page is cacheable |
| rsp_streamable | output | 1 | Page is streamable |
| rsp_fault | output | 1 | Translation failed |

## Verification
A flush register write and the return of a fetched entry can land in the same clock, and the flush may name the very page being filled. The bench's memory responder raises that flush write on the exact cycle it drives `mem_rsp_valid`. A repeat request to the same page must then produce a fresh memory read, seen as an increase in the bench's read counter. Random flushes also fall alongside hits and misses, and the cache state the bench predicts from the requirements decides whether each request should read memory.

// File: rtl/dvma_pkg.sv
// Package: shared constants, register selects, FSM states and the
// result type for the DVMA translator. Assumes 8 KB pages only.
package dvma_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 41;
    localparam int PG_SHIFT  = 13;
    localparam int ENT_W     = 64;
    localparam int CODE_W    = 3;
    localparam int WIN_SHIFT0 = 23;
    localparam int PPN_W     = PA_W - PG_SHIFT;
    localparam int PAGE_W    = VA_W - PG_SHIFT;

    // Entry bit positions decoded from memory
    localparam int E_VALID  = 63;
    localparam int E_STREAM = 60;
    localparam int E_CACHE  = 4;
    localparam int E_WRITE  = 1;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_FLUSH = 2'd2
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_FETCH, ST_WAIT, ST_RESP
    } state_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             wr_ok;
        logic             cache;
        logic             stream;
    } ent_fields_t;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        logic            cacheable;
        logic            streamable;
        logic            fault;
    } xlate_rsp_t;

    // Builds a response from entry fields; faults zero all other fields.
    function automatic xlate_rsp_t make_rsp(ent_fields_t f, logic vld,
                                            logic [PG_SHIFT-1:0] ofs,
                                            logic wr);
        xlate_rsp_t r;
        r = '0;
        if (!vld || (wr && !f.wr_ok)) begin
            r.fault = 1'b1;
        end else begin
            r.paddr      = {f.ppn, ofs};
            r.cacheable  = f.cache;
            r.streamable = f.stream;
        end
        return r;
    endfunction
endpackage

// File: rtl/dvma_cfg_regs.sv
// Configuration registers: control (enable, size code) and table base,
// plus decode of flush writes. Assumes writes take effect next cycle;
// flush and invalidate strobes are combinational from the write port.
module dvma_cfg_regs
    import dvma_pkg::*;
#(
    parameter int P_VA_W = VA_W,
    parameter int P_PA_W = PA_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [1:0]                   reg_sel,
    input  logic [63:0]                  reg_wdata,
    output logic                         en,
    output logic [CODE_W-1:0]            code,
    output logic [P_PA_W-1:0]            tbase,
    output logic                         flush_we,
    output logic [P_VA_W-PG_SHIFT-1:0]   flush_page,
    output logic                         cfg_changed
);
    logic unused_wdata;

    // Register update on writes to control or base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            code  <= '0;
            tbase <= '0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    en   <= reg_wdata[0];
                    code <= reg_wdata[18:16];
                end
                SEL_BASE: tbase <= reg_wdata[P_PA_W-1:0];
                default: ;
            endcase
        end
    end

    // Strobe decode for flush and configuration change
    always_comb begin
        flush_we    = reg_we && (reg_sel == SEL_FLUSH);
        flush_page  = reg_wdata[P_VA_W-1:PG_SHIFT];
        cfg_changed = reg_we && ((reg_sel == SEL_CTRL) || (reg_sel == SEL_BASE));
    end

    assign unused_wdata = ^{reg_wdata[63:P_PA_W], reg_wdata[PG_SHIFT-1:1]};
endmodule

// File: rtl/dvma_window.sv
// Window decode: derives the window base from the size code, flags
// addresses below it and forms the entry fetch address. Pure logic.
module dvma_window
    import dvma_pkg::*;
#(
    parameter int P_VA_W = VA_W,
    parameter int P_PA_W = PA_W
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [P_VA_W-1:0]  addr,
    input  logic [P_PA_W-1:0]  tbase,
    output logic               below,
    output logic [P_PA_W-1:0]  fetch_addr
);
    localparam logic [P_VA_W-1:0] ONES = '1;
    localparam int IDX_W = P_VA_W - PG_SHIFT;

    logic [P_VA_W-1:0] base;
    logic [P_VA_W-1:0] offset;
    logic [IDX_W-1:0]  index;
    logic              unused_ofs;

    // Base, range test, index and entry address
    always_comb begin
        base       = ONES << (WIN_SHIFT0 + int'(code));
        below      = addr < base;
        offset     = addr - base;
        index      = offset[P_VA_W-1:PG_SHIFT];
        fetch_addr = tbase + P_PA_W'({index, 3'b000});
    end

    assign unused_ofs = ^offset[PG_SHIFT-1:0];
endmodule

// File: rtl/dvma_entry_cache.sv
// Single-entry translation cache keyed by device page. Holds only valid
// entries. A flush naming the page being filled in the same cycle wins;
// a flush naming the looked-up page masks the hit in that cycle.
module dvma_entry_cache
    import dvma_pkg::*;
#(
    parameter int P_PAGE_W = PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inval_all,
    input  logic                 flush_we,
    input  logic [P_PAGE_W-1:0]  flush_page,
    input  logic                 fill_en,
    input  logic [P_PAGE_W-1:0]  fill_page,
    input  ent_fields_t          fill_fields,
    input  logic [P_PAGE_W-1:0]  look_page,
    output logic                 hit,
    output ent_fields_t          hit_fields
);
    logic                vld_q;
    logic [P_PAGE_W-1:0] key_q;
    ent_fields_t         ent_q;

    // Fill, flush and global invalidate of the cached entry
    always_ff @(posedge clk) begin
        if (!rst_n || inval_all) begin
            vld_q <= 1'b0;
            key_q <= '0;
            ent_q <= '0;
        end else if (fill_en) begin
            key_q <= fill_page;
            ent_q <= fill_fields;
            vld_q <= !(flush_we && (flush_page == fill_page));
        end else if (flush_we && (flush_page == key_q)) begin
            vld_q <= 1'b0;
        end
    end

    // Lookup against the current key
    always_comb begin
        hit        = vld_q && (key_q == look_page) &&
                     !(flush_we && (flush_page == look_page));
        hit_fields = ent_q;
    end
endmodule

// File: rtl/dvma_xlate.sv
// Top: DVMA translator. Accepts one request, checks enable and window,
// consults the cache, fetches one table entry on a miss and returns
// the physical address or a fault. Assumes memory returns each read's
// data in a later cycle than the read handshake.
module dvma_xlate
    import dvma_pkg::*;
#(
    parameter int P_VA_W = VA_W,
    parameter int P_PA_W = PA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [63:0]        reg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [P_VA_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [P_PA_W-1:0]  mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [P_PA_W-1:0]  rsp_paddr,
    output logic               rsp_cacheable,
    output logic               rsp_streamable,
    output logic               rsp_fault
);
    localparam int LPAGE_W = P_VA_W - PG_SHIFT;

    state_e              st_q;
    logic [P_VA_W-1:0]   addr_q;
    logic                wr_q;
    xlate_rsp_t          rsp_q;

    logic                en;
    logic [CODE_W-1:0]   code;
    logic [P_PA_W-1:0]   tbase;
    logic                flush_we;
    logic [LPAGE_W-1:0]  flush_page;
    logic                cfg_changed;
    logic                below;
    logic [P_PA_W-1:0]   fetch_addr;
    logic                hit;
    ent_fields_t         hit_fields;
    ent_fields_t         mem_fields;
    logic                fill_en;
    logic                unused_rsp;

    dvma_cfg_regs #(.P_VA_W(P_VA_W), .P_PA_W(P_PA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .en(en), .code(code), .tbase(tbase),
        .flush_we(flush_we), .flush_page(flush_page),
        .cfg_changed(cfg_changed)
    );

    dvma_window #(.P_VA_W(P_VA_W), .P_PA_W(P_PA_W)) u_win (
        .code(code), .addr(addr_q), .tbase(tbase),
        .below(below), .fetch_addr(fetch_addr)
    );

    dvma_entry_cache #(.P_PAGE_W(LPAGE_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .inval_all(cfg_changed),
        .flush_we(flush_we), .flush_page(flush_page),
        .fill_en(fill_en), .fill_page(addr_q[P_VA_W-1:PG_SHIFT]),
        .fill_fields(mem_fields), .look_page(addr_q[P_VA_W-1:PG_SHIFT]),
        .hit(hit), .hit_fields(hit_fields)
    );

    // Decode of fetched entry and fill strobe
    always_comb begin
        mem_fields.ppn    = mem_rsp_data[P_PA_W-1:PG_SHIFT];
        mem_fields.wr_ok  = mem_rsp_data[E_WRITE];
        mem_fields.cache  = mem_rsp_data[E_CACHE];
        mem_fields.stream = mem_rsp_data[E_STREAM];
        fill_en = (st_q == ST_WAIT) && mem_rsp_valid && mem_rsp_data[E_VALID];
    end

    // Request sequencing: accept, check, fetch, wait, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            wr_q   <= 1'b0;
            rsp_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    addr_q <= req_addr;
                    wr_q   <= req_write;
                    st_q   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!en || below) begin
                        rsp_q       <= '0;
                        rsp_q.fault <= 1'b1;
                        st_q        <= ST_RESP;
                    end else if (hit) begin
                        rsp_q <= make_rsp(hit_fields, 1'b1,
                                          addr_q[PG_SHIFT-1:0], wr_q);
                        st_q  <= ST_RESP;
                    end else begin
                        st_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_rd_ready) st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    rsp_q <= make_rsp(mem_fields, mem_rsp_data[E_VALID],
                                      addr_q[PG_SHIFT-1:0], wr_q);
                    st_q  <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state and result register
    always_comb begin
        req_ready      = (st_q == ST_IDLE);
        mem_rd_valid   = (st_q == ST_FETCH);
        mem_rd_addr    = fetch_addr;
        rsp_valid      = (st_q == ST_RESP);
        rsp_paddr      = rsp_q.paddr;
        rsp_cacheable  = rsp_q.cacheable;
        rsp_streamable = rsp_q.streamable;
        rsp_fault      = rsp_q.fault;
    end

    assign unused_rsp = ^{mem_rsp_data[62:61], mem_rsp_data[59:P_PA_W],
                          mem_rsp_data[PG_SHIFT-1:5], mem_rsp_data[3:2],
                          mem_rsp_data[0]};
endmodule

// File: rtl/dvma_xlate_chk.sv
// Checker for dvma_xlate port protocol; bound to every instance.
module dvma_xlate_chk #(
    parameter int P_PA_W = 41
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [P_PA_W-1:0] mem_rd_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [P_PA_W-1:0] rsp_paddr,
    input logic              rsp_cacheable,
    input logic              rsp_streamable,
    input logic              rsp_fault
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_rd_valid));

    a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_rd_valid) |-> !req_ready);

    a_r12_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
        $stable(rsp_fault) && $stable(rsp_cacheable) && $stable(rsp_streamable)));

    a_r12_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r4_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    a_r2_fault_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_cacheable && !rsp_streamable));
endmodule

bind dvma_xlate dvma_xlate_chk #(.P_PA_W(P_PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
    .rsp_streamable(rsp_streamable), .rsp_fault(rsp_fault)
);

// File: tb/dvma_xlate_tb.sv
module dvma_xlate_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [63:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [40:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [40:0] rsp_paddr;
    logic        rsp_cacheable;
    logic        rsp_streamable;
    logic        rsp_fault;

    dvma_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_cacheable(rsp_cacheable), .rsp_streamable(rsp_streamable),
        .rsp_fault(rsp_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int rd_count = 0;
    logic [40:0] last_rd = '0;
    logic [40:0] pend_addr = '0;
    bit pending = 0;
    bit coinc_en = 0;
    bit coinc_fired = 0;
    logic [31:0] coinc_addr = '0;

    // Reference state derived from the requirements
    bit          m_en = 0;
    logic [2:0]  m_code = '0;
    logic [40:0] m_tbase = '0;
    bit          m_cv = 0;
    logic [18:0] m_cpage = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(logic [40:0] a);
        logic [63:0] h;
        logic [63:0] e;
        h = {23'd0, a} * 64'h9E37_79B9_7F4A_7C15;
        h = h ^ (h >> 29);
        e = '0;
        e[63]    = (h[7:5] != 3'b000);
        e[60]    = h[20];
        e[59]    = h[21];
        e[40:13] = h[59:32];
        e[4]     = h[22];
        e[1]     = h[23];
        e[3]     = h[24];
        return e;
    endfunction

    function automatic logic [31:0] win_base(logic [2:0] c);
        return 32'hFFFF_FFFF << (23 + c);
    endfunction

    function automatic logic [40:0] fetch_of(logic [31:0] a);
        logic [31:0] idx;
        idx = (a - win_base(m_code)) >> 13;
        return m_tbase + {6'd0, idx, 3'b000};
    endfunction

    // Memory model: random read acceptance, data one cycle after handshake
    initial begin
        forever begin
            @(negedge clk);
            if (coinc_fired) begin
                reg_we = 1'b0;
                coinc_fired = 0;
            end
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = entry_of(pend_addr);
                pending = 0;
                if (coinc_en) begin
                    reg_we = 1'b1;
                    reg_sel = 2'd2;
                    reg_wdata = {32'd0, coinc_addr};
                    coinc_en = 0;
                    coinc_fired = 1;
                end
            end
            mem_rd_ready = ($urandom_range(0, 3) != 0);
            if (mem_rd_valid && mem_rd_ready) begin
                pending = 1;
                pend_addr = mem_rd_addr;
                last_rd = mem_rd_addr;
                rd_count++;
            end
        end
    end

    task automatic write_reg(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel == 2'd0) begin
            m_en = d[0]; m_code = d[18:16]; m_cv = 0;
        end else if (sel == 2'd1) begin
            m_tbase = d[40:0]; m_cv = 0;
        end else if (sel == 2'd2) begin
            if (m_cv && d[31:13] == m_cpage) m_cv = 0;
        end
    endtask

    // One translation with full expected-value checking
    task automatic do_xlate(input logic [31:0] a, input bit wr, input string tag,
                            input bit coinc);
        bit below, hit, rd_exp, f_exp;
        logic [40:0] fa, p_exp;
        logic [63:0] e;
        int n0;
        below  = a < win_base(m_code);
        fa     = fetch_of(a);
        e      = entry_of(fa);
        hit    = m_en && !below && m_cv && (m_cpage == a[31:13]);
        rd_exp = m_en && !below && !hit;
        f_exp  = !m_en || below || !e[63] || (wr && !e[1]);
        p_exp  = f_exp ? 41'd0 : {e[40:13], a[12:0]};
        if (coinc) begin
            coinc_addr = a;
            coinc_en = 1;
        end
        n0 = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R12 busy ", tag}, 64'(req_ready), 64'd0);
        forever begin
            if (rsp_valid) begin
                rsp_ready = 1'($urandom_range(0, 1));
                if (rsp_ready) break;
            end else begin
                rsp_ready = 1'b0;
            end
            @(negedge clk);
        end
        chk(rsp_fault == f_exp, {"R2/R6/R7 fault ", tag}, 64'(rsp_fault), 64'(f_exp));
        chk(rsp_paddr == p_exp, {"R5 paddr ", tag}, 64'(rsp_paddr), 64'(p_exp));
        chk(rsp_cacheable == (!f_exp && e[4]), {"R5 cacheable ", tag},
            64'(rsp_cacheable), 64'(!f_exp && e[4]));
        chk(rsp_streamable == (!f_exp && e[60]), {"R5 streamable ", tag},
            64'(rsp_streamable), 64'(!f_exp && e[60]));
        chk((rd_count - n0) == int'(rd_exp), {"R4/R8 reads ", tag},
            64'(rd_count - n0), 64'(rd_exp));
        if (rd_exp)
            chk(last_rd == fa, {"R4 fetch addr ", tag}, 64'(last_rd), 64'(fa));
        if (rd_exp && e[63] && !coinc) begin
            m_cv = 1; m_cpage = a[31:13];
        end else if (rd_exp && coinc) begin
            m_cv = 0;
        end
    endtask

    function automatic logic [31:0] find_page(input int kind);
        logic [31:0] a;
        logic [63:0] e;
        for (int k = 0; k < 1024; k++) begin
            a = win_base(m_code) + 32'(k) * 32'h2000 + 32'h0123;
            e = entry_of(fetch_of(a));
            if (kind == 0 && e[63] && e[1]) return a;
            if (kind == 1 && !e[63]) return a;
            if (kind == 2 && e[63] && !e[1]) return a;
        end
        return win_base(m_code);
    endfunction

    initial begin
        logic [31:0] a, b, base;
        int n0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_valid, "R1 reset outputs",
            {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);

        do_xlate(32'hFFF0_0000, 0, "R2 disabled", 0);

        write_reg(2'd1, 64'h12_3456_7000);
        write_reg(2'd0, 64'h0000_0000_0000_0007);   // R13 bits 1,2 set, ignored
        do_xlate(32'hFFFF_FFFF, 0, "R3 top of code0", 0);
        chk(last_rd == 41'h12_3456_7000 + 41'd8184, "R4 index 1023", 64'(last_rd),
            64'(41'h12_3456_7000 + 41'd8184));
        do_xlate(32'hFF80_0000, 0, "R3 code0 base", 0);
        do_xlate(32'hFF7F_FFFF, 0, "R3 below code0", 0);

        a = find_page(0);
        do_xlate(a, 0, "R8 miss", 0);
        do_xlate(a ^ 32'h0000_1ABC, 1, "R8 hit", 0);
        write_reg(2'd2, {32'd0, a ^ 32'h0000_2000});
        do_xlate(a, 0, "R9 other flush keeps", 0);
        write_reg(2'd2, {32'd0, a});
        do_xlate(a, 0, "R9 same flush drops", 0);
        write_reg(2'd3, 64'h0);
        do_xlate(a, 0, "R13 sel3 no effect", 0);
        write_reg(2'd1, 64'h12_3456_7000);
        do_xlate(a, 0, "R11 base write drops", 0);

        b = find_page(1);
        do_xlate(b, 0, "R6 invalid", 0);
        do_xlate(b, 0, "R6 invalid refetch", 0);
        b = find_page(2);
        do_xlate(b, 0, "R7 read ok", 0);
        do_xlate(b, 1, "R7 write fault", 0);

        a = find_page(0);
        do_xlate(a, 0, "R10 coincident flush", 1);
        n0 = rd_count;
        do_xlate(a, 0, "R10 refetch", 0);
        chk(rd_count == n0 + 1, "R10 fill dropped", 64'(rd_count), 64'(n0 + 1));

        write_reg(2'd0, 64'h0000_0000_0007_0001);
        do_xlate(32'hC000_0000, 0, "R3 code7 base", 0);
        chk(last_rd == 41'h12_3456_7000, "R4 index 0", 64'(last_rd), 64'(41'h12_3456_7000));
        do_xlate(32'hBFFF_FFFF, 0, "R3 below code7", 0);

        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 8) begin
                write_reg(2'd0, {45'd0, 3'($urandom_range(0, 7)), 13'd0,
                                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 9) != 0)});
            end else if (op < 18) begin
                b = ($urandom_range(0, 1) != 0) ? {m_cpage, 13'h0} : $urandom;
                write_reg(2'd2, {32'd0, b});
            end else begin
                base = win_base(m_code);
                if (op < 28) a = $urandom % base;
                else if (op < 50 && m_cv) a = {m_cpage, 13'($urandom)};
                else a = base + ($urandom % (32'h0080_0000 << m_code));
                do_xlate(a, 1'($urandom_range(0, 1)), "R3/R5/R8 random", 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule